// File: doc/BRIEF.md
# Two-Bank Interrupt Aggregator with Edge Latches

This block collects 64 interrupt request lines and presents them to a processor as two outputs: a normal request `irq` and a fast request `fiq`. Each line can be taken as a level or as an edge that is held in a latch. Each line also has its own enable, its own software trigger and its own choice of output. The sources are split into two banks of 32. Software reads and writes the block through a plain synchronous register port. Each register comes as a pair of 32-bit words: the low bank sits at the base offset and the high bank sits 4 bytes above it.

Enables and software triggers have separate set and clear addresses. Software therefore changes a single source by writing a one-hot word, with no read-modify-write. A service routine reads the normal or fast status word, finds a set bit, handles that source and then writes the same bit to the latch-clear address. For level sources that write has no effect, because the pending state follows the input line.

Top module: `vic_dual_bank`

## Requirements
- R1: Source n belongs to bank n>>5 at bit n&31. The register index is the byte offset >> 3, in this table: 0 normal status, 1 fast status, 2 raw status, 3 route, 4 enable-set, 5 enable-clear, 6 trigger-set, 7 trigger-clear, 8 sense, 9 dual-edge, 10 polarity, 11 latch-clear, 12 latch status. Offset bit 2 selects the high bank. An access to one bank never changes the other bank.
- R2: Writing ones at enable-set (0x20/0x24) enables those sources. Writing ones at enable-clear (0x28/0x2C) disables them. Zero bits have no effect. The enable word reads back at the enable-set offset one cycle after the write.
- R3: Writing ones at trigger-set (0x30/0x34) sets soft-trigger bits. Writing ones at trigger-clear (0x38/0x3C) clears them. The trigger word reads back at the trigger-set offset. A set trigger bit forces that source's raw bit to 1.
- R4: Route bit 0 sends an enabled pending source to `irq` and route bit 1 sends it to `fiq` (route word at 0x18/0x1C, read/write). `irq` is high when any normal status bit is set, and `fiq` is high when any fast status bit is set.
- R5: Sense bit 0 selects edge mode. In edge mode a detected event sets a latch, and the latch holds until a 1 is written to that bit at latch-clear (0x58/0x5C). The latch word reads at 0x60/0x64. In level mode a latch-clear write has no effect on the pending state.
- R6: Polarity bit 1 selects a rising edge or an active-high level; polarity bit 0 selects a falling edge or an active-low level. An edge is taken on the clock edge where the input differs from its sample one cycle earlier. A level source's raw bit follows the input within the same cycle.
- R7: Dual-edge bit 1 makes both rising and falling transitions set the latch, whatever the polarity.
- R8: When an edge event and a latch-clear write hit the same bit in the same cycle, the latch ends up set.
- R9: Raw status (0x10/0x14) = (sense ? level-qualified input : latch) | trigger. Normal status (0x00/0x04) = raw & enable & ~route. Fast status (0x08/0x0C) = raw & enable & route.
- R10: After reset, enables, triggers, routes, sense, dual-edge and latches are all 0, and polarity is all ones. `irq` and `fiq` are low.
- R11: Reads at the clear-only offsets (0x28, 0x2C, 0x38, 0x3C, 0x58, 0x5C) and at offsets from 0x68 up return 0. An access whose two low address bits are not zero reads 0 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | ADDR_W (8) | Byte offset of the access |
| wdata | input | BANK_W (32) | Write data |
| rdata | output | BANK_W (32) | Read data for `addr`, valid in the same cycle |
| src_in | input | NUM_SRC (64) | Interrupt request lines, synchronous to `clk` |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
Two functions can land on the same latch bit in the same cycle: the edge detector raising it and a software latch-clear write lowering it. The bench provokes this by driving a rising edge on a source in the same cycle that it writes that bit to the latch-clear address. It then reads the latch status word on the following cycle and expects the bit to be set. The other test cases keep the two functions in separate cycles: each source in turn is latched, reported, and then cleared and read back as 0.

// File: rtl/vic_pkg.sv
package vic_pkg;

  // register index = byte offset >> 3
  localparam int RI_IRQ_ST  = 0;
  localparam int RI_FIQ_ST  = 1;
  localparam int RI_RAW_ST  = 2;
  localparam int RI_ROUTE   = 3;
  localparam int RI_EN_SET  = 4;
  localparam int RI_EN_CLR  = 5;
  localparam int RI_TRG_SET = 6;
  localparam int RI_TRG_CLR = 7;
  localparam int RI_SENSE   = 8;
  localparam int RI_DUAL    = 9;
  localparam int RI_POL     = 10;
  localparam int RI_LAT_CLR = 11;
  localparam int RI_LAT_ST  = 12;

  // per-bank write strobes
  typedef struct packed {
    logic route;
    logic en_set;
    logic en_clr;
    logic trg_set;
    logic trg_clr;
    logic sense;
    logic dual;
    logic pol;
    logic lat_clr;
  } bank_wr_t;

endpackage

// File: rtl/vic_addr_dec.sv
module vic_addr_dec
  import vic_pkg::*;
#(
  parameter int NBANK  = 2,
  parameter int ADDR_W = 8,
  localparam int BSEL_W = $clog2(NBANK),
  localparam int IDX_W  = ADDR_W - 2 - BSEL_W
) (
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  output bank_wr_t [NBANK-1:0]  wr_vec,
  output logic [IDX_W-1:0]      rd_idx,
  output logic [BSEL_W-1:0]     rd_bank,
  output logic                  rd_ok
);

  logic              aligned;
  logic [IDX_W-1:0]  idx;
  logic [BSEL_W-1:0] bank;

  assign aligned = (addr[1:0] == 2'b00);
  assign idx     = addr[ADDR_W-1 -: IDX_W];
  assign bank    = addr[2 +: BSEL_W];

  assign rd_idx  = idx;
  assign rd_bank = bank;
  assign rd_ok   = aligned;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic     hit;
    bank_wr_t s;
    assign hit = wr_en && aligned && (bank == BSEL_W'(b));
    always_comb begin
      s         = '0;
      s.route   = hit && (idx == IDX_W'(RI_ROUTE));
      s.en_set  = hit && (idx == IDX_W'(RI_EN_SET));
      s.en_clr  = hit && (idx == IDX_W'(RI_EN_CLR));
      s.trg_set = hit && (idx == IDX_W'(RI_TRG_SET));
      s.trg_clr = hit && (idx == IDX_W'(RI_TRG_CLR));
      s.sense   = hit && (idx == IDX_W'(RI_SENSE));
      s.dual    = hit && (idx == IDX_W'(RI_DUAL));
      s.pol     = hit && (idx == IDX_W'(RI_POL));
      s.lat_clr = hit && (idx == IDX_W'(RI_LAT_CLR));
    end
    assign wr_vec[b] = s;
  end

endmodule

// File: rtl/vic_bank.sv
module vic_bank
  import vic_pkg::*;
#(
  parameter int BW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bank_wr_t      wr,
  input  logic [BW-1:0] wdata,
  input  logic [BW-1:0] src_in,
  output logic [BW-1:0] irq_st,
  output logic [BW-1:0] fiq_st,
  output logic [BW-1:0] raw_st,
  output logic [BW-1:0] route_q,
  output logic [BW-1:0] en_q,
  output logic [BW-1:0] trg_q,
  output logic [BW-1:0] sense_q,
  output logic [BW-1:0] dual_q,
  output logic [BW-1:0] pol_q,
  output logic [BW-1:0] lat_q
);

  logic [BW-1:0] route_d, en_d, trg_d, sense_d, dual_d, pol_d, lat_d;
  logic [BW-1:0] prev_q;
  logic [BW-1:0] rise, fall, evt, lat_set, lat_clr_m, lvl_hit;
  logic          cfg_ce;

  // event detection against previous sample
  always_comb begin
    rise      = src_in & ~prev_q;
    fall      = ~src_in & prev_q;
    evt       = (dual_q & (rise | fall)) |
                (~dual_q & ((pol_q & rise) | (~pol_q & fall)));
    lat_set   = evt & ~sense_q;
    lat_clr_m = wr.lat_clr ? wdata : '0;
    lvl_hit   = ~(src_in ^ pol_q);
  end

  // next state
  always_comb begin
    cfg_ce  = wr.route | wr.sense | wr.dual | wr.pol;
    route_d = wr.route ? wdata : route_q;
    sense_d = wr.sense ? wdata : sense_q;
    dual_d  = wr.dual  ? wdata : dual_q;
    pol_d   = wr.pol   ? wdata : pol_q;

    en_d = en_q;
    if (wr.en_set) en_d = en_d | wdata;
    if (wr.en_clr) en_d = en_d & ~wdata;

    trg_d = trg_q;
    if (wr.trg_set) trg_d = trg_d | wdata;
    if (wr.trg_clr) trg_d = trg_d & ~wdata;

    // a new event outranks a clear in the same cycle
    lat_d = lat_set | (lat_q & ~lat_clr_m);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
      sense_q <= '0;
      dual_q  <= '0;
      pol_q   <= '1;
      en_q    <= '0;
      trg_q   <= '0;
      lat_q   <= '0;
      prev_q  <= '0;
    end else begin
      if (cfg_ce) begin
        route_q <= route_d;
        sense_q <= sense_d;
        dual_q  <= dual_d;
        pol_q   <= pol_d;
      end
      en_q   <= en_d;
      trg_q  <= trg_d;
      lat_q  <= lat_d;
      prev_q <= src_in;
    end
  end

  // status words
  always_comb begin
    raw_st = (sense_q & lvl_hit) | (~sense_q & lat_q) | trg_q;
    irq_st = raw_st & en_q & ~route_q;
    fiq_st = raw_st & en_q & route_q;
  end

endmodule

// File: rtl/vic_rd_mux.sv
module vic_rd_mux
  import vic_pkg::*;
#(
  parameter int NBANK = 2,
  parameter int BW    = 32,
  parameter int IDX_W = 5,
  localparam int BSEL_W = $clog2(NBANK)
) (
  input  logic [IDX_W-1:0]          rd_idx,
  input  logic [BSEL_W-1:0]         rd_bank,
  input  logic                      rd_ok,
  input  logic [NBANK-1:0][BW-1:0]  irq_w,
  input  logic [NBANK-1:0][BW-1:0]  fiq_w,
  input  logic [NBANK-1:0][BW-1:0]  raw_w,
  input  logic [NBANK-1:0][BW-1:0]  route_w,
  input  logic [NBANK-1:0][BW-1:0]  en_w,
  input  logic [NBANK-1:0][BW-1:0]  trg_w,
  input  logic [NBANK-1:0][BW-1:0]  sense_w,
  input  logic [NBANK-1:0][BW-1:0]  dual_w,
  input  logic [NBANK-1:0][BW-1:0]  pol_w,
  input  logic [NBANK-1:0][BW-1:0]  lat_w,
  output logic [BW-1:0]             rdata
);

  always_comb begin
    rdata = '0;
    if (rd_ok) begin
      case (rd_idx)
        IDX_W'(RI_IRQ_ST):  rdata = irq_w[rd_bank];
        IDX_W'(RI_FIQ_ST):  rdata = fiq_w[rd_bank];
        IDX_W'(RI_RAW_ST):  rdata = raw_w[rd_bank];
        IDX_W'(RI_ROUTE):   rdata = route_w[rd_bank];
        IDX_W'(RI_EN_SET):  rdata = en_w[rd_bank];
        IDX_W'(RI_TRG_SET): rdata = trg_w[rd_bank];
        IDX_W'(RI_SENSE):   rdata = sense_w[rd_bank];
        IDX_W'(RI_DUAL):    rdata = dual_w[rd_bank];
        IDX_W'(RI_POL):     rdata = pol_w[rd_bank];
        IDX_W'(RI_LAT_ST):  rdata = lat_w[rd_bank];
        default:            rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/vic_dual_bank.sv
module vic_dual_bank
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int BANK_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BANK_W-1:0]  wdata,
  output logic [BANK_W-1:0]  rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               irq,
  output logic               fiq
);

  localparam int NBANK  = NUM_SRC / BANK_W;
  localparam int BSEL_W = $clog2(NBANK);
  localparam int IDX_W  = ADDR_W - 2 - BSEL_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_q1, rst_q2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  bank_wr_t [NBANK-1:0]        wr_vec;
  logic [IDX_W-1:0]            rd_idx;
  logic [BSEL_W-1:0]           rd_bank;
  logic                        rd_ok;
  logic [NBANK-1:0][BANK_W-1:0] irq_w, fiq_w, raw_w, route_w, en_w;
  logic [NBANK-1:0][BANK_W-1:0] trg_w, sense_w, dual_w, pol_w, lat_w;
  logic [NUM_SRC-1:0]          en_all, lat_all;

  vic_addr_dec #(.NBANK(NBANK), .ADDR_W(ADDR_W)) u_dec (
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_vec  (wr_vec),
    .rd_idx  (rd_idx),
    .rd_bank (rd_bank),
    .rd_ok   (rd_ok)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    vic_bank #(.BW(BANK_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_q2),
      .wr      (wr_vec[b]),
      .wdata   (wdata),
      .src_in  (src_in[b*BANK_W +: BANK_W]),
      .irq_st  (irq_w[b]),
      .fiq_st  (fiq_w[b]),
      .raw_st  (raw_w[b]),
      .route_q (route_w[b]),
      .en_q    (en_w[b]),
      .trg_q   (trg_w[b]),
      .sense_q (sense_w[b]),
      .dual_q  (dual_w[b]),
      .pol_q   (pol_w[b]),
      .lat_q   (lat_w[b])
    );
  end

  vic_rd_mux #(.NBANK(NBANK), .BW(BANK_W), .IDX_W(IDX_W)) u_rd (
    .rd_idx  (rd_idx),
    .rd_bank (rd_bank),
    .rd_ok   (rd_ok),
    .irq_w   (irq_w),
    .fiq_w   (fiq_w),
    .raw_w   (raw_w),
    .route_w (route_w),
    .en_w    (en_w),
    .trg_w   (trg_w),
    .sense_w (sense_w),
    .dual_w  (dual_w),
    .pol_w   (pol_w),
    .lat_w   (lat_w),
    .rdata   (rdata)
  );

  assign en_all  = en_w;
  assign lat_all = lat_w;
  assign irq     = |irq_w;
  assign fiq     = |fiq_w;

endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
  parameter int NUM_SRC = 64,
  parameter int BANK_W  = 32,
  parameter int ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [BANK_W-1:0]  wdata,
  input logic [BANK_W-1:0]  rdata,
  input logic               irq,
  input logic               fiq,
  input logic [NUM_SRC-1:0] en_all,
  input logic [NUM_SRC-1:0] lat_all
);

  localparam int NBANK  = NUM_SRC / BANK_W;
  localparam int BSEL_W = $clog2(NBANK);
  localparam int IDX_W  = ADDR_W - 2 - BSEL_W;

  logic [IDX_W-1:0]  idx;
  logic [BSEL_W-1:0] bank;
  logic              al;
  assign idx  = addr[ADDR_W-1 -: IDX_W];
  assign bank = addr[2 +: BSEL_W];
  assign al   = (addr[1:0] == 2'b00);

  for (genvar b = 0; b < NBANK; b++) begin : g_chk
    // R2: ones written at enable-set are enabled afterwards
    a_r2_en_set: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && al && idx == IDX_W'(4) && bank == BSEL_W'(b)) |=>
      ((en_all[b*BANK_W +: BANK_W] & $past(wdata)) == $past(wdata)));

    // R2: all-zero enable-clear leaves enables untouched
    a_r2_zero_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && al && idx == IDX_W'(5) && bank == BSEL_W'(b) && wdata == '0) |=>
      $stable(en_all[b*BANK_W +: BANK_W]));

    // R5: without a latch-clear write to the bank, no latch falls
    a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && al && idx == IDX_W'(11) && bank == BSEL_W'(b)) |=>
      ((lat_all[b*BANK_W +: BANK_W] & $past(lat_all[b*BANK_W +: BANK_W])) ==
       $past(lat_all[b*BANK_W +: BANK_W])));
  end

  // R4: nothing enabled means both outputs quiet
  a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all == '0) |-> (!irq && !fiq));

  // R11: unmapped or misaligned reads return zero
  a_r11_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (!al || idx > IDX_W'(12)) |-> (rdata == '0));

endmodule

bind vic_dual_bank vic_chk #(
  .NUM_SRC (NUM_SRC),
  .BANK_W  (BANK_W),
  .ADDR_W  (ADDR_W)
) u_vic_chk (
  .clk     (clk),
  .rst_n   (rst_q2),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .irq     (irq),
  .fiq     (fiq),
  .en_all  (en_all),
  .lat_all (lat_all)
);

// File: tb/test_vic_dual_bank.sv
`timescale 1ns/1ps
module test_vic_dual_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic [63:0] src_in = 64'h0;
  logic        irq, fiq;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  vic_dual_bank i_vic_dual_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .src_in(src_in), .irq(irq), .fiq(fiq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    rd(8'h20, v); chk("R10 en lo", v, 32'h0);
    rd(8'h24, v); chk("R10 en hi", v, 32'h0);
    rd(8'h18, v); chk("R10 route", v, 32'h0);
    rd(8'h40, v); chk("R10 sense", v, 32'h0);
    rd(8'h4C, v); chk("R10 dual", v, 32'h0);
    rd(8'h50, v); chk("R10 pol lo", v, 32'hFFFF_FFFF);
    rd(8'h54, v); chk("R10 pol hi", v, 32'hFFFF_FFFF);
    rd(8'h34, v); chk("R10 trig", v, 32'h0);
    chk("R10 outputs", {30'h0, irq, fiq}, 32'h0);

    // R1 R4 R5 R9: every source latched, routed, cleared
    for (int n = 0; n < 64; n++) begin
      logic [7:0]  off, oth;
      logic [31:0] bit_w;
      logic        odd;
      off   = 8'((n >> 5) * 4);
      oth   = 8'(4 - (n >> 5) * 4);
      bit_w = 32'h1 << (n & 31);
      odd   = n[0];
      wr(8'h20 + off, bit_w);
      if (odd) wr(8'h18 + off, bit_w);
      chk("R4 idle", {30'h0, irq, fiq}, 32'h0);
      src_in[n] = 1'b1;
      @(negedge clk);
      rd(8'h60 + off, v); chk("R5 latched", v, bit_w);
      rd((odd ? 8'h08 : 8'h00) + off, v); chk("R9 status", v, bit_w);
      chk("R4 route", {30'h0, irq, fiq}, odd ? 32'h1 : 32'h2);
      rd(8'h60 + oth, v); chk("R1 other bank", v, 32'h0);
      src_in[n] = 1'b0;
      @(negedge clk);
      rd(8'h60 + off, v); chk("R6 fall ignored", v, bit_w);
      wr(8'h58 + off, bit_w);
      rd(8'h60 + off, v); chk("R5 cleared", v, 32'h0);
      wr(8'h28 + off, bit_w);
      if (odd) wr(8'h18 + off, 32'h0);
    end

    // R6 level, active high then active low; R5 clear is no-op on level
    wr(8'h40, 32'h8); wr(8'h20, 32'h8);
    src_in[3] = 1'b1; #1;
    chk("R6 level high", {31'h0, irq}, 32'h1);
    rd(8'h10, v); chk("R9 raw level", v, 32'h8);
    wr(8'h58, 32'h8); #1;
    chk("R5 level clr nop", {31'h0, irq}, 32'h1);
    src_in[3] = 1'b0; #1;
    chk("R6 level drop", {31'h0, irq}, 32'h0);
    wr(8'h50, ~32'h8); #1;
    chk("R6 active low", {31'h0, irq}, 32'h1);
    wr(8'h50, 32'hFFFF_FFFF); wr(8'h28, 32'h8); wr(8'h40, 32'h0);

    // R6 falling edge
    wr(8'h50, ~32'h20); wr(8'h20, 32'h20);
    src_in[5] = 1'b1; @(negedge clk);
    rd(8'h60, v); chk("R6 rise ignored", v, 32'h0);
    src_in[5] = 1'b0; @(negedge clk);
    rd(8'h60, v); chk("R6 fall latched", v, 32'h20);
    wr(8'h58, 32'h20); wr(8'h50, 32'hFFFF_FFFF); wr(8'h28, 32'h20);

    // R7 dual edge on source 40
    wr(8'h4C, 32'h100); wr(8'h24, 32'h100);
    src_in[40] = 1'b1; @(negedge clk);
    rd(8'h64, v); chk("R7 rise", v, 32'h100);
    wr(8'h5C, 32'h100);
    src_in[40] = 1'b0; @(negedge clk);
    rd(8'h64, v); chk("R7 fall", v, 32'h100);
    chk("R7 irq", {31'h0, irq}, 32'h1);
    wr(8'h5C, 32'h100); wr(8'h4C, 32'h0); wr(8'h2C, 32'h100);

    // R3 soft trigger on source 34
    wr(8'h34, 32'h4);
    rd(8'h34, v); chk("R3 trig rb", v, 32'h4);
    rd(8'h14, v); chk("R3 raw", v, 32'h4);
    chk("R3 masked", {31'h0, irq}, 32'h0);
    wr(8'h24, 32'h4); #1;
    chk("R3 irq", {31'h0, irq}, 32'h1);
    wr(8'h3C, 32'h4);
    rd(8'h34, v); chk("R3 trig clr", v, 32'h0);
    chk("R3 irq off", {31'h0, irq}, 32'h0);
    wr(8'h2C, 32'h4);

    // R2 set/clear pairs and zero writes
    wr(8'h20, 32'hF0); wr(8'h28, 32'h0);
    rd(8'h20, v); chk("R2 zero clr", v, 32'hF0);
    wr(8'h20, 32'h0);
    rd(8'h20, v); chk("R2 zero set", v, 32'hF0);
    wr(8'h28, 32'h30);
    rd(8'h20, v); chk("R2 partial clr", v, 32'hC0);
    rd(8'h24, v); chk("R1 hi untouched", v, 32'h0);
    wr(8'h28, 32'hFFFF_FFFF);

    // R8 event and clear in the same cycle
    wr(8'h20, 32'h80);
    @(negedge clk);
    src_in[7] = 1'b1; wr_en = 1'b1; addr = 8'h58; wdata = 32'h80;
    @(negedge clk);
    wr_en = 1'b0;
    rd(8'h60, v); chk("R8 set wins", v, 32'h80);
    chk("R8 irq", {31'h0, irq}, 32'h1);
    wr(8'h58, 32'h80);
    src_in[7] = 1'b0; @(negedge clk);
    rd(8'h60, v); chk("R8 cleared", v, 32'h0);
    wr(8'h28, 32'h80);

    // R11 unmapped, clear-only and misaligned reads; misaligned write ignored
    wr(8'h40, 32'h1);
    rd(8'h28, v); chk("R11 en clr rd", v, 32'h0);
    rd(8'h3C, v); chk("R11 trg clr rd", v, 32'h0);
    rd(8'h5C, v); chk("R11 lat clr rd", v, 32'h0);
    rd(8'h68, v); chk("R11 0x68", v, 32'h0);
    rd(8'hFC, v); chk("R11 0xFC", v, 32'h0);
    rd(8'h41, v); chk("R11 misaligned rd", v, 32'h0);
    wr(8'h42, 32'hFFFF_FFFF);
    rd(8'h40, v); chk("R11 misaligned wr", v, 32'h1);
    wr(8'h40, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule